// File: doc/BRIEF.md
# Scaled Product Multiplier

This block is a single-cycle 16 × 16 multiplier. Each operation can be signed (two's complement) or unsigned. The 32-bit result is captured in a product register when a start strobe is high. A product scaler reads that register and feeds the accumulator datapath downstream. It applies one of four fixed shifts, chosen by a 2-bit mode input:

- no shift;
- a left shift by one;
- a left shift by four;
- an arithmetic right shift by six, which leaves headroom when many products are later summed.

The scaler is purely combinational, so a change of mode takes effect on the scaled output without a clock edge. The raw registered product is also visible on its own port. Operand fetch and accumulation belong to neighbouring blocks.

Top module: `mulscale_top`

## Requirements
- R1: While `rst` is high at a rising edge, the product register clears to zero. After that edge, `product` and `scaled_product` both read 0.
- R2: With `signed_en` = 0, a rising edge with `start` = 1 loads `product` with the unsigned 32-bit product of `op_a` and `op_b`. An example is 0xFFFF × 0xFFFF = 0xFFFE0001.
- R3: With `signed_en` = 1, the operands are read as two's-complement values and `product` receives the low 32 bits of their signed product. Examples: 0xFFFF × 0xFFFF = 0x00000001, and 0x8000 × 0x8000 = 0x40000000.
- R4: A rising edge with `start` = 0 leaves `product` unchanged, whatever the operands and sign select do.
- R5: `shift_mode` = 2'b00 makes `scaled_product` equal to `product`.
- R6: `shift_mode` = 2'b01 shifts `product` left by one. A zero enters at bit 0, bit 31 is discarded, and there is no saturation. The signed product 0x40000000 from 0x8000 × 0x8000 therefore scales to 0x80000000.
- R7: `shift_mode` = 2'b10 shifts `product` left by four. Zeros enter at the bottom and the top four bits are discarded.
- R8: `shift_mode` = 2'b11 shifts `product` right by six, arithmetically. Bit 31 of the product fills the top six bits of the result.
- R9: `scaled_product` depends only on the current `product` and the current `shift_mode`. A mode change alters it within the same cycle, with no clock edge and no change to `product`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load the product register at this edge |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| signed_en | input | 1 | 1: two's-complement operands, 0: unsigned |
| shift_mode | input | 2 | 00 none, 01 left 1, 10 left 4, 11 arithmetic right 6 |
| product | output | 32 | Registered raw product |
| scaled_product | output | 32 | Product after the selected scaling |

## Verification
The load checks assume that the operands and the sign select are settled at the edge where `start` is sampled. They also assume that `start` is a known level on every edge outside reset. The scaling checks assume that `shift_mode` always holds one of its four legal codes.

The bench drives every input on the falling edge, so values are stable well before each sampling edge. It raises `start` for exactly one edge per operation and then lowers it before any hold scenario. It steps `shift_mode` only through the four encodings, reading `scaled_product` mid-cycle after each step.

// File: rtl/mulscale_pkg.sv
package mulscale_pkg;

    localparam int OP_W   = 16;
    localparam int PROD_W = 2 * OP_W;

    typedef enum logic [1:0] {
        SHM_PASS = 2'b00,
        SHM_UP1  = 2'b01,
        SHM_UP4  = 2'b10,
        SHM_DN6  = 2'b11
    } shm_e;

    typedef struct packed {
        logic [OP_W-1:0] a;
        logic [OP_W-1:0] b;
        logic            sgn;
    } mul_req_t;

    // Extend an operand by one bit so that a single signed multiply covers both modes
    function automatic logic [OP_W:0] widen(input logic [OP_W-1:0] v, input logic sgn);
        return {sgn & v[OP_W-1], v};
    endfunction

endpackage

// File: rtl/mulscale_mult.sv
module mulscale_mult
    import mulscale_pkg::*;
#(
    parameter int W  = OP_W,
    localparam int PW = 2 * W
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic          sgn,
    output logic [PW-1:0] p
);
    logic signed [W:0]    a_x;
    logic signed [W:0]    b_x;
    logic signed [PW+1:0] full;

    always_comb begin
        a_x  = $signed({sgn & a[W-1], a});
        b_x  = $signed({sgn & b[W-1], b});
        full = a_x * b_x;
        p    = full[PW-1:0];
    end
endmodule

// File: rtl/mulscale_preg.sv
module mulscale_preg #(
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [PW-1:0] d,
    output logic [PW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/mulscale_scaler.sv
module mulscale_scaler
    import mulscale_pkg::*;
#(
    parameter int PW      = PROD_W,
    parameter int UP_LO   = 1,
    parameter int UP_HI   = 4,
    parameter int DN_AMT  = 6
) (
    input  logic [PW-1:0] p,
    input  shm_e          mode,
    output logic [PW-1:0] y
);
    localparam int NMODE = 4;

    logic [PW-1:0] cand [NMODE];

    for (genvar m = 0; m < NMODE; m++) begin : g_variant
        if (m == int'(SHM_PASS)) begin : g_pass
            assign cand[m] = p;
        end else if (m == int'(SHM_UP1)) begin : g_lo
            assign cand[m] = {p[PW-1-UP_LO:0], {UP_LO{1'b0}}};
        end else if (m == int'(SHM_UP4)) begin : g_hi
            assign cand[m] = {p[PW-1-UP_HI:0], {UP_HI{1'b0}}};
        end else begin : g_dn
            assign cand[m] = {{DN_AMT{p[PW-1]}}, p[PW-1:DN_AMT]};
        end
    end

    always_comb begin
        y = cand[mode];
    end
endmodule

// File: rtl/mulscale_top.sv
module mulscale_top
    import mulscale_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  logic              signed_en,
    input  logic [1:0]        shift_mode,
    output logic [PROD_W-1:0] product,
    output logic [PROD_W-1:0] scaled_product
);
    mul_req_t          req;
    logic [PROD_W-1:0] raw;
    shm_e              mode;

    always_comb begin
        req.a   = op_a;
        req.b   = op_b;
        req.sgn = signed_en;
        mode    = shm_e'(shift_mode);
    end

    mulscale_mult #(.W(OP_W)) u_mult (
        .a   (req.a),
        .b   (req.b),
        .sgn (req.sgn),
        .p   (raw)
    );

    mulscale_preg #(.PW(PROD_W)) u_preg (
        .clk  (clk),
        .rst  (rst),
        .load (start),
        .d    (raw),
        .q    (product)
    );

    mulscale_scaler #(.PW(PROD_W), .UP_LO(1), .UP_HI(4), .DN_AMT(6)) u_scaler (
        .p    (product),
        .mode (mode),
        .y    (scaled_product)
    );
endmodule

// File: rtl/mulscale_chk.sv
module mulscale_chk
    import mulscale_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [OP_W-1:0]   op_a,
    input logic [OP_W-1:0]   op_b,
    input logic              signed_en,
    input logic [1:0]        shift_mode,
    input logic [PROD_W-1:0] product,
    input logic [PROD_W-1:0] scaled_product
);
    logic [PROD_W-1:0] ref_u;
    logic [PROD_W-1:0] ref_s;

    always_comb begin
        ref_u = {{OP_W{1'b0}}, op_a} * {{OP_W{1'b0}}, op_b};
        ref_s = $signed({{OP_W{op_a[OP_W-1]}}, op_a}) * $signed({{OP_W{op_b[OP_W-1]}}, op_b});
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) $past(rst) |-> product == '0);

    // R2
    unsigned_load_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !signed_en) |=> product == $past(ref_u));

    // R3
    signed_load_chk: assert property (@(posedge clk) disable iff (rst)
        (start && signed_en) |=> product == $past(ref_s));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(product));

    // R5
    pass_mode_chk: assert property (@(posedge clk) disable iff (rst)
        shift_mode == 2'b00 |-> scaled_product == product);

    // R6
    up1_mode_chk: assert property (@(posedge clk) disable iff (rst)
        shift_mode == 2'b01 |-> scaled_product == PROD_W'(product * 2));

    // R7
    up4_mode_chk: assert property (@(posedge clk) disable iff (rst)
        shift_mode == 2'b10 |-> scaled_product == PROD_W'(product * 16));

    // R8
    dn6_mode_chk: assert property (@(posedge clk) disable iff (rst)
        shift_mode == 2'b11 |-> (scaled_product[PROD_W-7:0] == product[PROD_W-1:6]
                                 && $countones(scaled_product[PROD_W-1:PROD_W-6])
                                    == (product[PROD_W-1] ? 6 : 0)));
endmodule

bind mulscale_top mulscale_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .op_a           (op_a),
    .op_b           (op_b),
    .signed_en      (signed_en),
    .shift_mode     (shift_mode),
    .product        (product),
    .scaled_product (scaled_product)
);

// File: tb/mulscale_top_bench.sv
module mulscale_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        signed_en = 1'b0;
    logic [1:0]  shift_mode = 2'b00;
    logic [31:0] product;
    logic [31:0] scaled_product;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    mulscale_top u_mulscale_top (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .op_a           (op_a),
        .op_b           (op_b),
        .signed_en      (signed_en),
        .shift_mode     (shift_mode),
        .product        (product),
        .scaled_product (scaled_product)
    );

    function automatic logic [31:0] model_prod(logic [15:0] a, logic [15:0] b, bit s);
        longint x = s ? longint'($signed(a)) : longint'(a);
        longint y = s ? longint'($signed(b)) : longint'(b);
        longint r = x * y;
        return r[31:0];
    endfunction

    function automatic logic [31:0] model_scale(logic [31:0] p, logic [1:0] m);
        longint v;
        case (m)
            2'b00:   v = longint'(p);
            2'b01:   v = longint'(p) * 2;
            2'b10:   v = longint'(p) * 16;
            default: v = longint'($signed(p)) >>> 6;
        endcase
        return v[31:0];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic run_mul(logic [15:0] a, logic [15:0] b, bit s);
        @(negedge clk);
        op_a = a; op_b = b; signed_en = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 product after reset", product, 32'h0);
        check("R1 scaled after reset", scaled_product, 32'h0);
    endtask

    task automatic t_unsigned();
        logic [15:0] av [4] = '{16'hFFFF, 16'h1234, 16'h0000, 16'h8000};
        logic [15:0] bv [4] = '{16'hFFFF, 16'h5678, 16'hABCD, 16'h0002};
        shift_mode = 2'b00;
        for (int i = 0; i < 4; i++) begin
            run_mul(av[i], bv[i], 1'b0);
            check("R2 unsigned product", product, model_prod(av[i], bv[i], 1'b0));
        end
        check("R2 ffff*ffff literal", model_prod(16'hFFFF, 16'hFFFF, 1'b0), 32'hFFFE0001);
    endtask

    task automatic t_signed();
        logic [15:0] av [4] = '{16'hFFFF, 16'h8000, 16'h8000, 16'h7FFF};
        logic [15:0] bv [4] = '{16'hFFFF, 16'h8000, 16'h7FFF, 16'hFFFE};
        for (int i = 0; i < 4; i++) begin
            run_mul(av[i], bv[i], 1'b1);
            check("R3 signed product", product, model_prod(av[i], bv[i], 1'b1));
        end
        run_mul(16'h8000, 16'h8000, 1'b1);
        check("R3 0x8000 squared", product, 32'h40000000);
    endtask

    task automatic t_hold();
        logic [31:0] keep;
        run_mul(16'h0F0F, 16'h00F3, 1'b0);
        keep = product;
        @(negedge clk);
        op_a = 16'hFFFF; op_b = 16'h7777; signed_en = 1'b1;
        @(negedge clk);
        op_a = 16'h0001; signed_en = 1'b0;
        @(negedge clk);
        check("R4 hold without start", product, keep);
    endtask

    task automatic t_modes();
        logic [15:0] av [3] = '{16'h8000, 16'h8000, 16'h1357};
        logic [15:0] bv [3] = '{16'h8000, 16'h7FFF, 16'h9BDF};
        bit          sv [3] = '{1'b1, 1'b1, 1'b0};
        for (int i = 0; i < 3; i++) begin
            run_mul(av[i], bv[i], sv[i]);
            for (int m = 0; m < 4; m++) begin
                shift_mode = 2'(m);
                #2;
                case (m)
                    0: check("R5 pass mode", scaled_product, model_scale(product, 2'(m)));
                    1: check("R6 left-1 mode", scaled_product, model_scale(product, 2'(m)));
                    2: check("R7 left-4 mode", scaled_product, model_scale(product, 2'(m)));
                    default: check("R8 right-6 mode", scaled_product, model_scale(product, 2'(m)));
                endcase
            end
        end
        run_mul(16'h8000, 16'h8000, 1'b1);
        shift_mode = 2'b01;
        #2;
        check("R6 no saturation", scaled_product, 32'h80000000);
        run_mul(16'h8000, 16'h7FFF, 1'b1);
        shift_mode = 2'b11;
        #2;
        check("R8 sign fill", scaled_product, 32'hFF000200);
    endtask

    task automatic t_comb();
        logic [31:0] p0;
        run_mul(16'hABCD, 16'h1234, 1'b1);
        p0 = product;
        shift_mode = 2'b00;
        #2;
        check("R9 mode 00", scaled_product, p0);
        shift_mode = 2'b10;
        #2;
        check("R9 same-cycle mode change", scaled_product, model_scale(p0, 2'b10));
        check("R9 product untouched", product, p0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_unsigned();
        t_signed();
        t_hold();
        t_modes();
        t_comb();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule